// File: doc/BRIEF.md
# Two-Stage Watchdog Trip

The block is a watchdog that sits on a free-running binary divider clocked by the instruction clock. Every time the divider's top bit falls, that is, every time the divider wraps from all ones back to zero, the block advances a two-step alarm. The first wrap after a restart arms a first sticky flag. A second wrap while that flag is still set arms a second sticky flag. Software restarts the watchdog with a one-cycle strobe, which drops both flags. Normal code therefore has up to two full divider periods to service the watchdog, not one.

When the second flag is set and the watchdog function is enabled, the block raises a reset request. The request stays high for a fixed number of cycles. The block then returns to idle with both flags cleared. The divider itself never stops and is never restarted, so the time until the next wrap depends only on how long it has been since reset. The two flags come out on ports so the rest of the system can observe them.

Top module: `wdt_dual_trip`

## Requirements
- R1: The divider is DIV_W bits wide, starts at zero after reset and counts up by one every clock, wrapping from all ones to zero. A wrap is recognised as a falling transition of its top bit, so the first wrap acts on the flags at clock edge 2^DIV_W+1 after reset release.
- R2: A wrap while the first flag is clear sets the first flag, which `flag_first_o` shows as 1.
- R3: A wrap while the first flag is set also sets the second flag (`flag_second_o` = 1). The first flag stays set, and the second flag is never set while the first is clear.
- R4: A high `restart_i` at a clock edge clears both flags at that edge. This also applies while a reset request is being held, in which case the request still completes its full length.
- R5: When the second flag is set and `wdt_en_i` is high, `rst_req_o` goes high at the next clock edge and stays high for exactly HOLD_CYCLES cycles.
- R6: At the edge where `rst_req_o` falls, both flags are cleared and the block is idle again. A wrap at that same edge does not set a flag.
- R7: When `restart_i` and a wrap act on the same edge, the restart wins and both flags are clear after that edge.
- R8: While `wdt_en_i` is low, a set second flag stays set and produces no request. Once `wdt_en_i` goes high, the request starts at the next edge.
- R9: Driving `rst_ni` low clears the divider, both flags and the request at once, without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Instruction clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wdt_en_i | input | 1 | Lets a set second flag raise the reset request |
| restart_i | input | 1 | One-cycle software restart strobe, clears both flags |
| rst_req_o | output | 1 | Reset request, held for HOLD_CYCLES cycles |
| flag_first_o | output | 1 | First sticky flag, set by a wrap |
| flag_second_o | output | 1 | Second sticky flag, set by a wrap while the first flag is set |

## Verification
The bench builds the block with DIV_W = 3 and HOLD_CYCLES = 4. With these values a wrap acts on the flags every eight cycles, so a short per-cycle schedule covers many cases. It takes the block through a full trip, a restart between wraps, and a restart that lands on the same edge as a wrap. It also covers a second flag held while the enable is low, a request released by raising the enable later, and a restart that arrives in the middle of a held request. Because the request is only four cycles long, the bench can confirm where it starts and ends, and that the flags clear on the falling edge of the request, without running through long periods.

// File: rtl/wdt_dual_pkg.sv
package wdt_dual_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HOLD = 1'b1
  } wd_state_e;
endpackage

// File: rtl/wdt_divider.sv
module wdt_divider #(
  parameter int unsigned DIV_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic wrap_o
);
  localparam int unsigned MSB = DIV_W - 1;
  localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

  logic [DIV_W-1:0] cnt_q;
  logic             msb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      msb_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + ONE;
      msb_q <= cnt_q[MSB];
    end
  end

  // falling edge of the top bit marks the all-ones to zero wrap
  assign wrap_o = msb_q & ~cnt_q[MSB];
endmodule

// File: rtl/wdt_flags.sv
module wdt_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wrap_i,
  input  logic restart_i,
  input  logic clear_i,
  output logic first_o,
  output logic second_o
);
  logic first_q, second_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q  <= 1'b0;
      second_q <= 1'b0;
    end else if (restart_i || clear_i) begin
      // clearing wins over a coincident wrap
      first_q  <= 1'b0;
      second_q <= 1'b0;
    end else if (wrap_i) begin
      if (first_q) second_q <= 1'b1;
      else         first_q  <= 1'b1;
    end
  end

  assign first_o  = first_q;
  assign second_o = second_q;
endmodule

// File: rtl/wdt_stretch.sv
module wdt_stretch
  import wdt_dual_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trip_i,
  output logic req_o,
  output logic done_o
);
  localparam int unsigned HCW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [HCW-1:0] LAST = HCW'(HOLD_CYCLES - 1);
  localparam logic [HCW-1:0] STEP = {{(HCW-1){1'b0}}, 1'b1};

  wd_state_e      state_q;
  logic [HCW-1:0] hold_q;
  logic           last_w;

  assign last_w = (state_q == ST_HOLD) && (hold_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      hold_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          hold_q <= '0;
          if (trip_i) state_q <= ST_HOLD;
        end
        ST_HOLD: begin
          if (last_w) begin
            state_q <= ST_IDLE;
            hold_q  <= '0;
          end else begin
            hold_q <= hold_q + STEP;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_o  = (state_q == ST_HOLD);
  assign done_o = last_w;
endmodule

// File: rtl/wdt_dual_trip.sv
module wdt_dual_trip #(
  parameter int unsigned DIV_W       = 16,
  parameter int unsigned HOLD_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wdt_en_i,
  input  logic restart_i,
  output logic rst_req_o,
  output logic flag_first_o,
  output logic flag_second_o
);
  logic wrap_w, done_w, first_w, second_w, req_w, trip_w;

  wdt_divider #(.DIV_W(DIV_W)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wrap_o(wrap_w)
  );

  wdt_flags u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wrap_i   (wrap_w),
    .restart_i(restart_i),
    .clear_i  (done_w),
    .first_o  (first_w),
    .second_o (second_w)
  );

  assign trip_w = second_w & wdt_en_i;

  wdt_stretch #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .trip_i(trip_w),
    .req_o (req_w),
    .done_o(done_w)
  );

  assign rst_req_o     = req_w;
  assign flag_first_o  = first_w;
  assign flag_second_o = second_w;
endmodule

// File: rtl/wdt_dual_trip_chk.sv
module wdt_dual_trip_chk #(
  parameter int unsigned HOLD_CYCLES = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic wdt_en_i,
  input logic restart_i,
  input logic rst_req_o,
  input logic flag_first_o,
  input logic flag_second_o
);
  localparam int unsigned RW = $clog2(HOLD_CYCLES + 2);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        run_q <= '0;
    else if (rst_req_o) run_q <= run_q + {{(RW-1){1'b0}}, 1'b1};
    else                run_q <= '0;
  end

  p_second_needs_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_second_o |-> flag_first_o);

  p_second_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_second_o) |-> $past(flag_first_o));

  p_restart_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (!flag_first_o && !flag_second_o));

  p_req_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> $past(flag_second_o && wdt_en_i));

  p_hold_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_req_o) |-> (run_q == RW'(HOLD_CYCLES)));

  p_hold_cap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RW'(HOLD_CYCLES));

  p_clear_at_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_req_o) |-> (!flag_first_o && !flag_second_o));

  p_no_req_disabled_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rst_req_o && !wdt_en_i) |=> !rst_req_o);
endmodule

bind wdt_dual_trip wdt_dual_trip_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (.*);

// File: tb/wdt_dual_trip_test.sv
module wdt_dual_trip_test;
  localparam int unsigned DIV_W = 3;
  localparam int unsigned HOLD  = 4;
  localparam int NSEG = 15;

  // {first row, last row, en, restart, exp req, exp first, exp second}
  localparam logic [20:0] SEG [NSEG] = '{
    {8'd1,  8'd8,  5'b10000},  // R1: no wrap yet
    {8'd9,  8'd16, 5'b10010},  // R2: first wrap
    {8'd17, 8'd17, 5'b10011},  // R3: second wrap
    {8'd18, 8'd21, 5'b10111},  // R5: request held
    {8'd22, 8'd24, 5'b10000},  // R6: idle, flags clear
    {8'd25, 8'd26, 5'b10010},  // R2
    {8'd27, 8'd27, 5'b11000},  // R4: restart between wraps
    {8'd28, 8'd32, 5'b10000},  // R4
    {8'd33, 8'd33, 5'b11000},  // R7: restart with wrap
    {8'd34, 8'd40, 5'b10000},  // R7
    {8'd41, 8'd48, 5'b00010},  // R8: disabled
    {8'd49, 8'd51, 5'b00011},  // R8: second set, no request
    {8'd52, 8'd55, 5'b10111},  // R8: enable releases request
    {8'd56, 8'd56, 5'b10000},  // R6
    {8'd57, 8'd57, 5'b10010}   // R1: wrap every 2^DIV_W
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wdt_en_i = 1'b1;
  logic restart_i = 1'b0;
  logic rst_req_o, flag_first_o, flag_second_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  wdt_dual_trip #(.DIV_W(DIV_W), .HOLD_CYCLES(HOLD)) uut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wdt_en_i     (wdt_en_i),
    .restart_i    (restart_i),
    .rst_req_o    (rst_req_o),
    .flag_first_o (flag_first_o),
    .flag_second_o(flag_second_o)
  );

  function automatic string seg_tag(int s);
    case (s)
      0, 14:      return "R1";
      1, 5:       return "R2";
      2:          return "R3";
      3:          return "R5";
      4, 13:      return "R6";
      6, 7:       return "R4";
      8, 9:       return "R7";
      default:    return "R8";
    endcase
  endfunction

  task automatic chk(string tag, string what, int row, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s row %0d: actual %0b expected %0b", tag, what, row, act, exp);
    end
  endtask

  task automatic chk_all(string tag, int row, logic er, logic e1, logic e2);
    chk(tag, "req", row, rst_req_o, er);
    chk(tag, "first", row, flag_first_o, e1);
    chk(tag, "second", row, flag_second_o, e2);
  endtask

  task automatic step(logic en, logic rs);
    wdt_en_i  = en;
    restart_i = rs;
    @(posedge clk_i);
    #1;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk_all("R9", 0, rst_req_o, 1'b0, 1'b0);
    chk("R9", "req", 0, rst_req_o, 1'b0);
    rst_ni = 1'b1;
    chk_all("R9", 0, 1'b0, 1'b0, 1'b0);

    for (int s = 0; s < NSEG; s++) begin
      for (int r = int'(SEG[s][20:13]); r <= int'(SEG[s][12:5]); r++) begin
        wdt_en_i  = SEG[s][4];
        restart_i = SEG[s][3];
        @(posedge clk_i);
        #1;
        chk_all(seg_tag(s), r, SEG[s][2], SEG[s][1], SEG[s][0]);
        @(negedge clk_i);
      end
    end
    restart_i = 1'b0;

    // R9: asynchronous reset with the first flag set
    #1 rst_ni = 1'b0;
    #1;
    chk_all("R9", 100, 1'b0, 1'b0, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R4: restart during a held request
    for (int k = 1; k <= 17; k++) step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    chk_all("R5", 118, 1'b1, 1'b1, 1'b1);
    step(1'b1, 1'b1);
    chk_all("R4", 119, 1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    chk_all("R4", 121, 1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0);
    chk_all("R6", 122, 1'b0, 1'b0, 1'b0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule